// File: doc/BRIEF.md
# Interrupt Acknowledge and Nesting Tracker

This block sits between the per-CPU interrupt interface registers and the interrupt state store. For every CPU it holds the identifier of the interrupt now being serviced and that interrupt's priority. When a CPU accepts an interrupt, the block notes which interrupt was being serviced before it. Together these notes form a chain of preempted interrupts for each CPU. A request port carries two kinds of request: an acknowledge, which returns the interrupt the CPU must now service (or 1023 when there is none), and an end-of-interrupt, which retires an interrupt. The retired interrupt may be the one on top of the chain or one further down it.

Retiring the interrupt on top pops the chain in the same cycle. Retiring one further down starts a walk through the CPU's chain, one link per cycle. The walk stops when it finds the link that points at the retired identifier and splices that identifier out. New requests are held off while the walk runs. The pending bits, the priority table and the per-interrupt configuration live outside this block and are reached through simple ports. After every change to the state, a one-cycle strobe tells the priority resolver to evaluate again.

The state machine has two states. ST_IDLE accepts requests. An acknowledge or a top-of-chain completion returns to ST_IDLE. A completion that does not match the running ID takes the transition to ST_WALK. ST_WALK stays in ST_WALK while it follows the links, and takes the transition back to ST_IDLE when it splices, reaches the end of the chain (1023), reaches an identifier outside the table, or hits the step bound.

Top module: `irq_ack_tracker`

## Requirements
- R1: After reset, every CPU reports running ID 1023 and running priority 0x100 (9-bit), and `req_ready` is high.
- R2: An acknowledge returns ID 1023 and changes no state when the CPU's candidate from `hp_id_flat` is 1023, or when the candidate's 8-bit priority is not strictly below the CPU's running priority. The result appears on `ack_valid`/`ack_id` one cycle after the request is accepted.
- R3: A successful acknowledge returns the candidate ID. The candidate becomes the CPU's running ID, its priority becomes the running priority, and the previous running ID is stored as the candidate's link for that CPU.
- R4: A successful acknowledge pulses `pend_clr_valid` with the ID. `pend_clr_mask` has only the acknowledging CPU's bit set (bit n = CPU n), or all bits set when the interrupt's `irq_one_of_n` bit is 1.
- R5: An end-of-interrupt (ID in `req_data[9:0]`) is ignored when the CPU's running ID is 1023: no re-pend, no strobe, and no change to the running state.
- R6: An end-of-interrupt whose ID equals the running ID makes that ID's link the new running ID. The running priority becomes that ID's priority, or 0x100 when the new running ID is 1023.
- R7: An end-of-interrupt whose ID differs from the running ID leaves the running ID unchanged. It removes the ID from the chain, so later completions skip it.
- R8: Completing an ID below NUM_IRQ re-pends it for this CPU only (`pend_set_mask` one-hot). This happens when its `irq_edge` bit is 0 (level), its `irq_enabled` and `irq_level` bits are 1, and its `irq_target_flat` bit at index ID*NUM_CPU+CPU is 1.
- R9: While a chain walk runs, `req_ready` is low and no request changes the running state. The walk ends after at most NUM_IRQ steps.
- R10: `update_strobe` pulses after a successful acknowledge, a pop, a re-pend or a splice. It stays low for a rejected acknowledge and for an ignored completion.
- R11: Requests from one CPU never change another CPU's running ID or priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; accepted when `req_ready` is high |
| req_is_eoi | input | 1 | 1 = end-of-interrupt, 0 = acknowledge |
| req_cpu | input | CPU_W | Requesting CPU |
| req_data | input | 10 | Completed interrupt ID for end-of-interrupt |
| req_ready | output | 1 | High in ST_IDLE |
| ack_valid | output | 1 | Acknowledge result valid (one cycle) |
| ack_id | output | 10 | Acknowledged ID, or 1023 |
| hp_id_flat | input | NUM_CPU*10 | Highest pending candidate per CPU, 1023 if none |
| prio_q_id | output | 10 | Priority lookup ID |
| prio_q_cpu | output | CPU_W | Priority lookup CPU |
| prio_q_val | input | 8 | Looked-up priority (combinational) |
| irq_enabled | input | NUM_IRQ | Per-interrupt enable |
| irq_edge | input | NUM_IRQ | 1 = edge-triggered, 0 = level |
| irq_level | input | NUM_IRQ | Input line currently asserted |
| irq_one_of_n | input | NUM_IRQ | 1 = acknowledge clears all CPUs |
| irq_target_flat | input | NUM_IRQ*NUM_CPU | Target bit per (ID, CPU) |
| pend_clr_valid | output | 1 | Clear pending pulse |
| pend_clr_id | output | 10 | ID to clear |
| pend_clr_mask | output | NUM_CPU | CPUs to clear |
| pend_set_valid | output | 1 | Re-pend pulse |
| pend_set_id | output | 10 | ID to re-pend |
| pend_set_mask | output | NUM_CPU | CPU to re-pend |
| run_id_flat | output | NUM_CPU*10 | Running ID per CPU |
| run_prio_flat | output | NUM_CPU*9 | Running priority per CPU |
| update_strobe | output | 1 | Re-evaluate pending selection |

## Verification
The assertions check several properties on every cycle. A CPU's running ID is 1023 exactly when its running priority is 0x100. The running state cannot move in the cycle after a walk step. A successful acknowledge always carries a clear of the same ID, while a rejected one carries none. A re-pend always names exactly one CPU. Only the directed scenarios can show the chain order: nested acknowledges, a splice out of the middle followed by a pop that skips the spliced entry, and the return to 1023 at the bottom. The scenarios also cover the strict priority comparison and the gating of the re-pend by configuration.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
    localparam int unsigned ID_W    = 10;
    localparam int unsigned PRIO_W  = 8;
    localparam int unsigned RPRIO_W = 9;
    localparam logic [ID_W-1:0]    ID_NONE    = 10'd1023;
    localparam logic [RPRIO_W-1:0] RPRIO_IDLE = 9'h100;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } trk_state_e;
endpackage

// File: rtl/ack_link_table.sv
module ack_link_table
    import irq_ack_pkg::*;
#(
    parameter int unsigned NUM_CPU = 2,
    parameter int unsigned NUM_IRQ = 64,
    parameter int unsigned CPU_W   = 1,
    parameter int unsigned IDX_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] ra_irq,
    input  logic [CPU_W-1:0] ra_cpu,
    output logic [ID_W-1:0]  ra_data,
    input  logic [IDX_W-1:0] rb_irq,
    input  logic [CPU_W-1:0] rb_cpu,
    output logic [ID_W-1:0]  rb_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_irq,
    input  logic [CPU_W-1:0] wr_cpu,
    input  logic [ID_W-1:0]  wr_data
);
    localparam int unsigned ENTRIES = NUM_IRQ * NUM_CPU;
    localparam int unsigned ENT_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ID_W-1:0] link_q [ENTRIES];

    function automatic logic [ENT_W-1:0] ent_of(input logic [IDX_W-1:0] irq,
                                                 input logic [CPU_W-1:0] cpu);
        return ENT_W'(irq) * ENT_W'(NUM_CPU) + ENT_W'(cpu);
    endfunction

    assign ra_data = link_q[ent_of(ra_irq, ra_cpu)];
    assign rb_data = link_q[ent_of(rb_irq, rb_cpu)];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < int'(ENTRIES); e++) begin
                link_q[e] <= ID_NONE;
            end
        end else if (wr_en) begin
            link_q[ent_of(wr_irq, wr_cpu)] <= wr_data;
        end
    end
endmodule

// File: rtl/ack_run_state.sv
module ack_run_state
    import irq_ack_pkg::*;
#(
    parameter int unsigned NUM_CPU = 2,
    parameter int unsigned CPU_W   = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [CPU_W-1:0]           wr_cpu,
    input  logic [ID_W-1:0]            wr_id,
    input  logic [RPRIO_W-1:0]         wr_prio,
    output logic [NUM_CPU*ID_W-1:0]    run_id_flat,
    output logic [NUM_CPU*RPRIO_W-1:0] run_prio_flat
);
    for (genvar c = 0; c < int'(NUM_CPU); c++) begin : g_cpu
        logic [ID_W-1:0]    id_q;
        logic [RPRIO_W-1:0] prio_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                id_q   <= ID_NONE;
                prio_q <= RPRIO_IDLE;
            end else if (wr_en && (int'(wr_cpu) == c)) begin
                id_q   <= wr_id;
                prio_q <= wr_prio;
            end
        end

        assign run_id_flat[c*ID_W +: ID_W]          = id_q;
        assign run_prio_flat[c*RPRIO_W +: RPRIO_W] = prio_q;

        AST_IDLE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
            (id_q == ID_NONE) == (prio_q == RPRIO_IDLE)); // R6
    end
endmodule

// File: rtl/irq_ack_tracker.sv
module irq_ack_tracker
    import irq_ack_pkg::*;
#(
    parameter int unsigned NUM_CPU = 2,
    parameter int unsigned NUM_IRQ = 64,
    localparam int unsigned CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int unsigned IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic                        req_is_eoi,
    input  logic [CPU_W-1:0]            req_cpu,
    input  logic [ID_W-1:0]             req_data,
    output logic                        req_ready,
    output logic                        ack_valid,
    output logic [ID_W-1:0]             ack_id,
    input  logic [NUM_CPU*ID_W-1:0]     hp_id_flat,
    output logic [ID_W-1:0]             prio_q_id,
    output logic [CPU_W-1:0]            prio_q_cpu,
    input  logic [PRIO_W-1:0]           prio_q_val,
    input  logic [NUM_IRQ-1:0]          irq_enabled,
    input  logic [NUM_IRQ-1:0]          irq_edge,
    input  logic [NUM_IRQ-1:0]          irq_level,
    input  logic [NUM_IRQ-1:0]          irq_one_of_n,
    input  logic [NUM_IRQ*NUM_CPU-1:0]  irq_target_flat,
    output logic                        pend_clr_valid,
    output logic [ID_W-1:0]             pend_clr_id,
    output logic [NUM_CPU-1:0]          pend_clr_mask,
    output logic                        pend_set_valid,
    output logic [ID_W-1:0]             pend_set_id,
    output logic [NUM_CPU-1:0]          pend_set_mask,
    output logic [NUM_CPU*ID_W-1:0]     run_id_flat,
    output logic [NUM_CPU*RPRIO_W-1:0]  run_prio_flat,
    output logic                        update_strobe
);
    localparam int unsigned CNT_W = IDX_W + 1;
    localparam logic [ID_W-1:0]  IRQ_LIMIT  = ID_W'(NUM_IRQ);
    localparam logic [CNT_W-1:0] STEP_LIMIT = CNT_W'(NUM_IRQ);

    // FSM and walk registers
    trk_state_e       state_q, state_d;
    logic [CPU_W-1:0] walk_cpu_q, walk_cpu_d;
    logic [ID_W-1:0]  walk_tmp_q, walk_tmp_d;
    logic [ID_W-1:0]  walk_tgt_q, walk_tgt_d;
    logic [CNT_W-1:0] walk_cnt_q, walk_cnt_d;

    // request decode
    logic               req_fire;
    logic [ID_W-1:0]    cur_run_id;
    logic [RPRIO_W-1:0] cur_run_prio;
    logic [ID_W-1:0]    cur_hp;
    logic [ID_W-1:0]    eoi_id;
    logic [IDX_W-1:0]   eoi_idx;
    logic               eoi_real;
    logic [NUM_CPU-1:0] eoi_tgt_row;
    logic               ack_take, ack_reject;
    logic               eoi_live, eoi_pop, eoi_walk, repend;

    // link table ports
    logic [IDX_W-1:0] la_irq, lb_irq, lw_irq;
    logic [CPU_W-1:0] la_cpu, lb_cpu, lw_cpu;
    logic [ID_W-1:0]  la_data, lb_data, lw_data;
    logic             lw_en;

    // running state write port
    logic               rw_en;
    logic [CPU_W-1:0]   rw_cpu;
    logic [ID_W-1:0]    rw_id;
    logic [RPRIO_W-1:0] rw_prio;

    // walk step decode
    logic walk_end, walk_splice;

    assign req_ready    = (state_q == ST_IDLE);
    assign req_fire     = req_valid && req_ready;
    assign cur_run_id   = run_id_flat[req_cpu*ID_W +: ID_W];
    assign cur_run_prio = run_prio_flat[req_cpu*RPRIO_W +: RPRIO_W];
    assign cur_hp       = hp_id_flat[req_cpu*ID_W +: ID_W];
    assign eoi_id       = req_data;
    assign eoi_idx      = eoi_id[IDX_W-1:0];
    assign eoi_real     = (eoi_id < IRQ_LIMIT);
    assign eoi_tgt_row  = irq_target_flat[eoi_idx*NUM_CPU +: NUM_CPU];

    // link read port A: completed ID in ST_IDLE, walk cursor in ST_WALK
    assign la_irq = req_ready ? eoi_idx : walk_tmp_q[IDX_W-1:0];
    assign la_cpu = req_ready ? req_cpu : walk_cpu_q;
    // link read port B: the ID being spliced out
    assign lb_irq = walk_tgt_q[IDX_W-1:0];
    assign lb_cpu = walk_cpu_q;

    // one priority lookup per cycle: the candidate or the popped link
    assign prio_q_id  = req_is_eoi ? la_data : cur_hp;
    assign prio_q_cpu = req_cpu;

    assign ack_take   = req_fire && !req_is_eoi && (cur_hp < IRQ_LIMIT)
                        && ({1'b0, prio_q_val} < cur_run_prio);
    assign ack_reject = req_fire && !req_is_eoi && !ack_take;
    assign eoi_live   = req_fire && req_is_eoi && (cur_run_id != ID_NONE);
    assign eoi_pop    = eoi_live && (eoi_id == cur_run_id);
    assign eoi_walk   = eoi_live && (eoi_id != cur_run_id);
    assign repend     = eoi_live && eoi_real && !irq_edge[eoi_idx]
                        && irq_enabled[eoi_idx] && irq_level[eoi_idx]
                        && eoi_tgt_row[req_cpu];

    assign walk_splice = (state_q == ST_WALK) && (la_data == walk_tgt_q)
                         && (la_data < IRQ_LIMIT);
    assign walk_end    = (la_data == ID_NONE) || (la_data >= IRQ_LIMIT)
                         || (la_data == walk_tgt_q) || (walk_cnt_q >= STEP_LIMIT);

    ack_link_table #(
        .NUM_CPU (NUM_CPU),
        .NUM_IRQ (NUM_IRQ),
        .CPU_W   (CPU_W),
        .IDX_W   (IDX_W)
    ) u_links (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_irq  (la_irq),
        .ra_cpu  (la_cpu),
        .ra_data (la_data),
        .rb_irq  (lb_irq),
        .rb_cpu  (lb_cpu),
        .rb_data (lb_data),
        .wr_en   (lw_en),
        .wr_irq  (lw_irq),
        .wr_cpu  (lw_cpu),
        .wr_data (lw_data)
    );

    ack_run_state #(
        .NUM_CPU (NUM_CPU),
        .CPU_W   (CPU_W)
    ) u_run (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (rw_en),
        .wr_cpu        (rw_cpu),
        .wr_id         (rw_id),
        .wr_prio       (rw_prio),
        .run_id_flat   (run_id_flat),
        .run_prio_flat (run_prio_flat)
    );

    // next state, walk registers and table/run write controls
    always_comb begin
        state_d    = state_q;
        walk_cpu_d = walk_cpu_q;
        walk_tmp_d = walk_tmp_q;
        walk_tgt_d = walk_tgt_q;
        walk_cnt_d = walk_cnt_q;
        lw_en      = 1'b0;
        lw_irq     = cur_hp[IDX_W-1:0];
        lw_cpu     = req_cpu;
        lw_data    = cur_run_id;
        rw_en      = 1'b0;
        rw_cpu     = req_cpu;
        rw_id      = cur_hp;
        rw_prio    = {1'b0, prio_q_val};
        unique case (state_q)
            ST_IDLE: begin
                if (ack_take) begin
                    lw_en = 1'b1;
                    rw_en = 1'b1;
                end else if (eoi_pop) begin
                    rw_en   = 1'b1;
                    rw_id   = la_data;
                    rw_prio = (la_data == ID_NONE) ? RPRIO_IDLE : {1'b0, prio_q_val};
                end else if (eoi_walk) begin
                    state_d    = ST_WALK;
                    walk_cpu_d = req_cpu;
                    walk_tmp_d = cur_run_id;
                    walk_tgt_d = eoi_id;
                    walk_cnt_d = '0;
                end
            end
            ST_WALK: begin
                walk_cnt_d = walk_cnt_q + 1'b1;
                walk_tmp_d = la_data;
                if (walk_splice) begin
                    lw_en   = 1'b1;
                    lw_irq  = walk_tmp_q[IDX_W-1:0];
                    lw_cpu  = walk_cpu_q;
                    lw_data = lb_data;
                end
                if (walk_end) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            walk_cpu_q <= '0;
            walk_tmp_q <= ID_NONE;
            walk_tgt_q <= ID_NONE;
            walk_cnt_q <= '0;
        end else begin
            state_q    <= state_d;
            walk_cpu_q <= walk_cpu_d;
            walk_tmp_q <= walk_tmp_d;
            walk_tgt_q <= walk_tgt_d;
            walk_cnt_q <= walk_cnt_d;
        end
    end

    // registered result and side-effect pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_valid      <= 1'b0;
            ack_id         <= ID_NONE;
            pend_clr_valid <= 1'b0;
            pend_clr_id    <= ID_NONE;
            pend_clr_mask  <= '0;
            pend_set_valid <= 1'b0;
            pend_set_id    <= ID_NONE;
            pend_set_mask  <= '0;
            update_strobe  <= 1'b0;
        end else begin
            ack_valid      <= ack_take || ack_reject;
            ack_id         <= ack_take ? cur_hp : ID_NONE;
            pend_clr_valid <= ack_take;
            pend_clr_id    <= cur_hp;
            pend_clr_mask  <= irq_one_of_n[cur_hp[IDX_W-1:0]]
                              ? {NUM_CPU{1'b1}}
                              : (NUM_CPU'(1) << req_cpu);
            pend_set_valid <= repend;
            pend_set_id    <= eoi_id;
            pend_set_mask  <= NUM_CPU'(1) << req_cpu;
            update_strobe  <= ack_take || eoi_pop || repend || walk_splice;
        end
    end

    AST_WALK_HOLDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WALK) |=> $stable(run_id_flat)); // R9
    AST_ACK_CLEARS_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_id != ID_NONE) |-> (pend_clr_valid && pend_clr_id == ack_id)); // R4
    AST_REJECT_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_id == ID_NONE) |-> (!pend_clr_valid && !update_strobe)); // R2
    AST_REPEND_ONE_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        pend_set_valid |-> ($countones(pend_set_mask) == 1)); // R8
    AST_CLEAR_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pend_clr_valid |-> (pend_clr_mask != '0)); // R4
    AST_WALK_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WALK) |-> (walk_cnt_q <= STEP_LIMIT)); // R9
endmodule

// File: tb/tb_irq_ack_tracker.sv
module tb_irq_ack_tracker;
    localparam int NCPU = 2;
    localparam int NIRQ = 64;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                req_valid = 1'b0;
    logic                req_is_eoi = 1'b0;
    logic [0:0]          req_cpu = '0;
    logic [9:0]          req_data = '0;
    logic                req_ready;
    logic                ack_valid;
    logic [9:0]          ack_id;
    logic [NCPU*10-1:0]  hp_id_flat = {NCPU{10'd1023}};
    logic [9:0]          prio_q_id;
    logic [0:0]          prio_q_cpu;
    logic [7:0]          prio_q_val;
    logic [NIRQ-1:0]     irq_enabled = '0;
    logic [NIRQ-1:0]     irq_edge = '0;
    logic [NIRQ-1:0]     irq_level = '0;
    logic [NIRQ-1:0]     irq_one_of_n = '0;
    logic [NIRQ*NCPU-1:0] irq_target_flat = '0;
    logic                pend_clr_valid;
    logic [9:0]          pend_clr_id;
    logic [NCPU-1:0]     pend_clr_mask;
    logic                pend_set_valid;
    logic [9:0]          pend_set_id;
    logic [NCPU-1:0]     pend_set_mask;
    logic [NCPU*10-1:0]  run_id_flat;
    logic [NCPU*9-1:0]   run_prio_flat;
    logic                update_strobe;

    logic [7:0] prio_tb [NIRQ];
    assign prio_q_val = prio_tb[prio_q_id[5:0]];

    int n_checks = 0;
    int n_fail = 0;

    // captured results of the last request
    logic       g_ack_v, g_clr_v, g_set_v, g_upd, g_saw_busy;
    logic [9:0] g_ack_id, g_clr_id, g_set_id;
    logic [1:0] g_clr_m, g_set_m;

    always #5 clk = ~clk;

    irq_ack_tracker #(.NUM_CPU(NCPU), .NUM_IRQ(NIRQ)) dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic cpu, input logic eoi, input logic [9:0] data);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_is_eoi = eoi; req_cpu = cpu; req_data = data;
        @(negedge clk);
        req_valid = 1'b0;
        g_ack_v = ack_valid; g_ack_id = ack_id;
        g_clr_v = pend_clr_valid; g_clr_id = pend_clr_id; g_clr_m = pend_clr_mask;
        g_set_v = pend_set_valid; g_set_id = pend_set_id; g_set_m = pend_set_mask;
        g_upd = update_strobe; g_saw_busy = !req_ready;
        while (!req_ready) begin
            @(negedge clk);
            g_upd = g_upd | update_strobe;
        end
    endtask

    function automatic logic [9:0] rid(input int c);
        return run_id_flat[c*10 +: 10];
    endfunction
    function automatic logic [8:0] rpr(input int c);
        return run_prio_flat[c*9 +: 9];
    endfunction

    task automatic t_reset;
        check("R1 run id cpu0", rid(0), 10'd1023);
        check("R1 run id cpu1", rid(1), 10'd1023);
        check("R1 run prio cpu0", rpr(0), 9'h100);
        check("R1 ready", req_ready, 1);
    endtask

    task automatic t_reject;
        hp_id_flat[9:0] = 10'd1023;
        send(0, 0, 0);
        check("R2 no candidate id", g_ack_id, 10'd1023);
        check("R2 no candidate valid", g_ack_v, 1);
        check("R10 no strobe on reject", g_upd, 0);
    endtask

    task automatic t_nest;
        hp_id_flat[9:0] = 10'd12;
        send(0, 0, 0);
        check("R3 ack 12", g_ack_id, 10'd12);
        check("R3 run id 12", rid(0), 10'd12);
        check("R3 run prio 0x80", rpr(0), 9'h080);
        check("R4 clear own cpu", {g_clr_v, g_clr_id, g_clr_m}, {1'b1, 10'd12, 2'b01});
        check("R10 strobe on ack", g_upd, 1);
        send(0, 0, 0);
        check("R2 equal priority rejected", g_ack_id, 10'd1023);
        check("R2 running unchanged", rid(0), 10'd12);
        hp_id_flat[9:0] = 10'd5; send(0, 0, 0);
        hp_id_flat[9:0] = 10'd7; send(0, 0, 0);
        hp_id_flat[9:0] = 10'd9; send(0, 0, 0);
        check("R3 nested run id 9", rid(0), 10'd9);
        hp_id_flat[9:0] = 10'd1023;
    endtask

    task automatic t_splice;
        send(0, 1, 10'd7);
        check("R9 busy during walk", g_saw_busy, 1);
        check("R7 running stays 9", rid(0), 10'd9);
        check("R10 strobe on splice", g_upd, 1);
        send(0, 1, 10'd9);
        check("R7 pop skips spliced 7", rid(0), 10'd5);
        check("R6 prio follows pop", rpr(0), 9'h040);
    endtask

    task automatic t_one_of_n_repend;
        irq_one_of_n[20] = 1; irq_enabled[20] = 1; irq_level[20] = 1;
        irq_target_flat[20*NCPU + 0] = 1;
        hp_id_flat[9:0] = 10'd20;
        send(0, 0, 0);
        check("R4 one-of-N clears all", {g_clr_v, g_clr_m}, {1'b1, 2'b11});
        hp_id_flat[9:0] = 10'd1023;
        send(0, 1, 10'd20);
        check("R8 repend level irq", {g_set_v, g_set_id, g_set_m}, {1'b1, 10'd20, 2'b01});
        check("R6 back to 5", rid(0), 10'd5);
        irq_target_flat[20*NCPU + 0] = 0;
        hp_id_flat[9:0] = 10'd20;
        send(0, 0, 0);
        hp_id_flat[9:0] = 10'd1023;
        send(0, 1, 10'd20);
        check("R8 no repend when untargeted", g_set_v, 0);
        irq_target_flat[20*NCPU + 0] = 1;
    endtask

    task automatic t_unwind_and_ignore;
        send(0, 1, 10'd5);
        check("R6 pop to 12", {rid(0), rpr(0)}, {10'd12, 9'h080});
        send(0, 1, 10'd12);
        check("R6 pop to idle", {rid(0), rpr(0)}, {10'd1023, 9'h100});
        send(0, 1, 10'd20);
        check("R5 eoi ignored when idle", {g_set_v, g_upd}, 2'b00);
        check("R5 running still idle", rid(0), 10'd1023);
    endtask

    task automatic t_per_cpu;
        hp_id_flat[19:10] = 10'd7;
        send(1, 0, 0);
        check("R11 cpu1 runs 7", rid(1), 10'd7);
        check("R11 cpu0 untouched", rid(0), 10'd1023);
        check("R4 cpu1 clear mask", g_clr_m, 2'b10);
    endtask

    initial begin
        for (int i = 0; i < NIRQ; i++) prio_tb[i] = 8'hF0;
        prio_tb[5] = 8'h40; prio_tb[7] = 8'h20; prio_tb[9] = 8'h10;
        prio_tb[12] = 8'h80; prio_tb[20] = 8'h30;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reject();
        t_nest();
        t_splice();
        t_one_of_n_repend();
        t_unwind_and_ignore();
        t_per_cpu();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule